// File: doc/BRIEF.md
# Free-Running Timer with Capture and Compare

A 16-bit up-counter advances once for every cycle in which the `tick` enable is high. It reports three kinds of event: the counter reaching its all-ones value, the counter reaching a programmable compare value, and a chosen edge on an asynchronous capture input. For each event the block sets a status flag and can raise a level interrupt request. On a compare event it can also drive a programmed level onto an output pin. When the capture edge arrives, the block stores the counter value in a read-only register.

Software reaches the block through a plain byte-wide register port. Read data is combinational from `reg_addr`. The side effects of a read or a write take place at the clock edge where `reg_rd` or `reg_wr` is high. Each flag has its own clearing rule, based on the order of register accesses: the overflow flag needs a status read alone, the compare flag needs a status read followed by a compare write, and the capture flag needs a status read followed by a capture read. All pins are plain control and status signals, so there is no streaming handshake and no back-pressure.

Top module: `frt_capcmp`

## Requirements
- R1: Register addresses are 0 control/status, 1 counter high, 2 counter low, 3 compare high, 4 compare low, 5 capture high, 6 capture low. After reset the counter reads 0x0000, compare reads 0xFFFF, capture reads 0x0000, status reads 0x00, and `cmp_pin` and all three interrupt requests are low.
- R2: The counter rises by one on each clock edge with `tick` high, wraps from 0xFFFF to 0x0000, and holds when `tick` is low.
- R3: When a tick moves the counter to 0xFFFF, status bit 5 (overflow) sets.
- R4: When a tick moves the counter onto the compare value, status bit 6 sets. If `cmp_oe` is high, `cmp_pin` takes the value of status bit 0. If `cmp_oe` is low, the pin keeps its level.
- R5: `cap_in` passes through a two-stage synchronizer. Status bit 1 selects the edge: 1 means rising and 0 means falling. On the selected edge the counter value is stored in the capture register and status bit 7 sets. The other edge has no effect.
- R6: `irq_ovf`, `irq_cmp` and `irq_cap` are high while flag bit 5, 6 or 7 and enable bit 2, 3 or 4 respectively are both 1.
- R7: A status read that returns bit 5 set clears the overflow flag.
- R8: The compare flag clears only on a compare-register write that follows a status read that saw the flag. A compare write with no such status read leaves the flag set. A compare event that arrives in the same cycle as the clearing write wins.
- R9: The capture flag clears only on a capture-register read that follows a status read that saw the flag. A capture read alone leaves the flag set.
- R10: Status bits 0 to 4 are read/write. Writes do not change bits 5 to 7, the counter, or the capture register.
- R11: A read of the counter high byte stores the low byte at that instant. A later read of the low byte returns the stored value, even if the counter has advanced since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance enable |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| cap_in | input | 1 | Asynchronous capture input |
| cmp_oe | input | 1 | Output enable for the compare pin level |
| cmp_pin | output | 1 | Compare output level |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |
| irq_cap | output | 1 | Capture interrupt request |

## Verification
The bench writes the compare register without a preceding status read and reads capture without one. A design that cleared on the second access alone would drop the interrupt early. With the rising edge selected, the bench drives a falling edge on the capture input, and with the falling edge selected it drives a rising one. A design that ignored the edge select would overwrite the capture value. The bench reads the counter high byte, keeps ticking, and then reads the low byte; without the stored copy the halves would tear. The bench runs the counter through 0xFFFF into the wrap and toggles `cmp_oe` around compare matches, so a pin that followed the level with the enable low would show up.

// File: rtl/frt_pkg.sv
package frt_pkg;
  typedef enum logic [2:0] {
    A_STAT   = 3'd0,
    A_CNT_HI = 3'd1,
    A_CNT_LO = 3'd2,
    A_CMP_HI = 3'd3,
    A_CMP_LO = 3'd4,
    A_CAP_HI = 3'd5,
    A_CAP_LO = 3'd6
  } reg_addr_e;

  // control/status bit positions
  localparam int B_LVL    = 0;
  localparam int B_EDGE   = 1;
  localparam int B_IE_OVF = 2;
  localparam int B_IE_CAP = 4;
  localparam int CTL_W    = 5;

  // event indices
  localparam int N_EVT  = 3;
  localparam int EV_OVF = 0;
  localparam int EV_CMP = 1;
  localparam int EV_CAP = 2;

  // events whose flag needs a second access after the status read
  localparam logic [N_EVT-1:0] TWO_STEP_MASK = 3'b110;
endpackage

// File: rtl/frt_count.sv
module frt_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nx,
  output logic             top_evt
);
  localparam logic [CNT_W-1:0] TOP = '1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign count_nx = count + ONE;
  assign top_evt  = tick && (count_nx == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count_nx;
  end
endmodule

// File: rtl/frt_edge.sv
module frt_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic rise_sel,
  output logic evt
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;
  logic            now_lvl, old_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], din};
  end

  assign now_lvl = pipe[STAGES-1];
  assign old_lvl = pipe[STAGES];
  assign evt     = rise_sel ? (now_lvl & ~old_lvl) : (~now_lvl & old_lvl);
endmodule

// File: rtl/frt_flag.sv
module frt_flag #(
  parameter bit TWO_STEP = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic stat_rd,
  input  logic follow,
  output logic flag
);
  logic arm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      arm  <= 1'b0;
    end else if (set_evt) begin
      // a fresh event wins and needs a fresh status read
      flag <= 1'b1;
      arm  <= 1'b0;
    end else if (stat_rd && flag) begin
      if (TWO_STEP) arm  <= 1'b1;
      else          flag <= 1'b0;
    end else if (TWO_STEP && arm && follow) begin
      flag <= 1'b0;
      arm  <= 1'b0;
    end
  end
endmodule

// File: rtl/frt_capcmp.sv
module frt_capcmp
  import frt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [CNT_W/2-1:0] reg_wdata,
  output logic [CNT_W/2-1:0] reg_rdata,
  input  logic               cap_in,
  input  logic               cmp_oe,
  output logic               cmp_pin,
  output logic               irq_ovf,
  output logic               irq_cmp,
  output logic               irq_cap
);
  localparam int BYTE_W = CNT_W / 2;

  logic [CTL_W-1:0]  ctl_q;
  logic [CNT_W-1:0]  count, count_nx, cmp_q, cap_q;
  logic [BYTE_W-1:0] lo_buf;
  logic              pin_q;
  logic              ovf_evt, cmp_evt, cap_evt;
  logic [N_EVT-1:0]  set_evt, follow, flags;
  logic [7:0]        stat_byte;
  reg_addr_e         addr;
  logic              stat_rd, wr_stat, wr_cmp_hi, wr_cmp_lo, rd_cnt_hi, rd_cap;

  assign addr      = reg_addr_e'(reg_addr);
  assign stat_rd   = reg_rd && (addr == A_STAT);
  assign wr_stat   = reg_wr && (addr == A_STAT);
  assign wr_cmp_hi = reg_wr && (addr == A_CMP_HI);
  assign wr_cmp_lo = reg_wr && (addr == A_CMP_LO);
  assign rd_cnt_hi = reg_rd && (addr == A_CNT_HI);
  assign rd_cap    = reg_rd && ((addr == A_CAP_HI) || (addr == A_CAP_LO));

  frt_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .count    (count),
    .count_nx (count_nx),
    .top_evt  (ovf_evt)
  );

  frt_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (cap_in),
    .rise_sel (ctl_q[B_EDGE]),
    .evt      (cap_evt)
  );

  // compare uses the register value held before any same-cycle write
  assign cmp_evt = tick && (count_nx == cmp_q);

  assign set_evt[EV_OVF] = ovf_evt;
  assign set_evt[EV_CMP] = cmp_evt;
  assign set_evt[EV_CAP] = cap_evt;
  assign follow[EV_OVF]  = 1'b0;
  assign follow[EV_CMP]  = wr_cmp_hi || wr_cmp_lo;
  assign follow[EV_CAP]  = rd_cap;

  for (genvar g = 0; g < N_EVT; g++) begin : g_flag
    frt_flag #(.TWO_STEP(TWO_STEP_MASK[g])) u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (set_evt[g]),
      .stat_rd (stat_rd),
      .follow  (follow[g]),
      .flag    (flags[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      cmp_q  <= '1;
      cap_q  <= '0;
      lo_buf <= '0;
      pin_q  <= 1'b0;
    end else begin
      if (wr_stat)   ctl_q <= reg_wdata[CTL_W-1:0];
      if (wr_cmp_hi) cmp_q[CNT_W-1:BYTE_W] <= reg_wdata;
      if (wr_cmp_lo) cmp_q[BYTE_W-1:0]     <= reg_wdata;
      if (cap_evt)   cap_q <= count;
      if (rd_cnt_hi) lo_buf <= count[BYTE_W-1:0];
      if (cmp_evt && cmp_oe) pin_q <= ctl_q[B_LVL];
    end
  end

  assign stat_byte = {flags[EV_CAP], flags[EV_CMP], flags[EV_OVF], ctl_q};

  always_comb begin
    case (addr)
      A_STAT:   reg_rdata = BYTE_W'(stat_byte);
      A_CNT_HI: reg_rdata = count[CNT_W-1:BYTE_W];
      A_CNT_LO: reg_rdata = lo_buf;
      A_CMP_HI: reg_rdata = cmp_q[CNT_W-1:BYTE_W];
      A_CMP_LO: reg_rdata = cmp_q[BYTE_W-1:0];
      A_CAP_HI: reg_rdata = cap_q[CNT_W-1:BYTE_W];
      A_CAP_LO: reg_rdata = cap_q[BYTE_W-1:0];
      default:  reg_rdata = '0;
    endcase
  end

  assign {irq_cap, irq_cmp, irq_ovf} = flags & ctl_q[B_IE_CAP:B_IE_OVF];
  assign cmp_pin = pin_q;
endmodule

// File: rtl/frt_capcmp_chk.sv
module frt_capcmp_chk
  import frt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cmp_oe,
  input logic             cmp_pin,
  input logic             reg_rd,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cap_q,
  input logic             cap_evt,
  input logic [N_EVT-1:0] flags
);
  localparam logic [CNT_W-1:0] ALMOST = CNT_W'({CNT_W{1'b1}} - 1);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == CNT_W'($past(count) + 1'b1));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == ALMOST) |=> flags[EV_OVF]);

  assert_pin_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_oe |=> $stable(cmp_pin));

  assert_cap_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_q == $past(count));

  assert_cap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_q));

  assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[EV_OVF]) |-> $past(reg_rd && reg_addr == A_STAT));

  assert_cmp_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[EV_CMP]) |->
      $past(reg_wr && (reg_addr == A_CMP_HI || reg_addr == A_CMP_LO)));

  assert_cap_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[EV_CAP]) |->
      $past(reg_rd && (reg_addr == A_CAP_HI || reg_addr == A_CAP_LO)));
endmodule

bind frt_capcmp frt_capcmp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .cmp_oe   (cmp_oe),
  .cmp_pin  (cmp_pin),
  .reg_rd   (reg_rd),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .count    (count),
  .cap_q    (cap_q),
  .cap_evt  (cap_evt),
  .flags    (flags)
);

// File: tb/frt_capcmp_bench.sv
module frt_capcmp_bench;
  localparam logic [2:0] AS = 3'd0, ACH = 3'd1, ACL = 3'd2, AMH = 3'd3,
                         AML = 3'd4, APH = 3'd5, APL = 3'd6;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  logic       cap_in = 1'b0, cmp_oe = 1'b0;
  logic       cmp_pin, irq_ovf, irq_cmp, irq_cap;

  int checks = 0, errors = 0;
  logic [15:0] exp_cnt = 16'd0;

  always #4 clk = ~clk;

  frt_capcmp u_frt_capcmp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cap_in(cap_in), .cmp_oe(cmp_oe), .cmp_pin(cmp_pin),
    .irq_ovf(irq_ovf), .irq_cmp(irq_cmp), .irq_cap(irq_cap)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic tick_n(input int n);
    @(negedge clk); tick = 1'b1;
    for (int i = 0; i < n; i++) begin @(negedge clk); exp_cnt = exp_cnt + 16'd1; end
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cmp(input logic [15:0] v);
    wr(AMH, v[15:8]); wr(AML, v[7:0]);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(AS, d);  chk("R1 status", d, 8'h00);
    rd(ACH, d); chk("R1 count hi", d, 8'h00);
    rd(ACL, d); chk("R1 count lo", d, 8'h00);
    rd(AMH, d); chk("R1 compare hi", d, 8'hFF);
    rd(AML, d); chk("R1 compare lo", d, 8'hFF);
    rd(APH, d); chk("R1 capture hi", d, 8'h00);
    rd(APL, d); chk("R1 capture lo", d, 8'h00);
    chk("R1 pin and irqs", {cmp_pin, irq_ovf, irq_cmp, irq_cap}, 4'b0000);
  endtask

  task automatic t_status_rw;
    logic [7:0] d;
    wr(AS, 8'hFF); rd(AS, d); chk("R10 only bits 0-4 writable", d, 8'h1F);
    chk("R10 no irq from flag write", {irq_ovf, irq_cmp, irq_cap}, 3'b000);
    wr(AS, 8'h00); rd(AS, d); chk("R10 control cleared", d, 8'h00);
    wr(ACL, 8'h55); wr(APL, 8'h66);
    rd(ACH, d); rd(ACL, d); chk("R10 counter ignores write", d, exp_cnt[7:0]);
    rd(APL, d); chk("R10 capture ignores write", d, 8'h00);
  endtask

  task automatic t_count;
    logic [7:0] h, l;
    logic [15:0] snap;
    tick_n(5);
    rd(ACH, h); rd(ACL, l); chk("R2 count after 5 ticks", {h, l}, exp_cnt);
    idle(4);
    rd(ACH, h); rd(ACL, l); chk("R2 count holds without tick", {h, l}, exp_cnt);
    rd(ACH, h); snap = exp_cnt;
    tick_n(3);
    rd(ACL, l); chk("R11 low byte stored at high read", {h, l}, snap);
    rd(ACH, h); rd(ACL, l); chk("R11 fresh pair", {h, l}, exp_cnt);
  endtask

  task automatic t_compare;
    logic [7:0] d;
    cmp_oe = 1'b1;
    wr(AS, 8'h09);
    wr_cmp(exp_cnt + 16'd3);
    tick_n(2);
    chk("R4 no match early", irq_cmp, 1'b0);
    tick_n(1);
    chk("R4 pin takes level", cmp_pin, 1'b1);
    chk("R6 compare irq", irq_cmp, 1'b1);
    wr_cmp(exp_cnt + 16'd100);
    chk("R8 write alone keeps flag", irq_cmp, 1'b1);
    rd(AS, d); chk("R4 status shows compare flag", d, 8'h49);
    wr_cmp(exp_cnt + 16'd2);
    chk("R8 read then write clears", irq_cmp, 1'b0);
    wr(AS, 8'h08); cmp_oe = 1'b0;
    tick_n(2);
    chk("R4 pin held with enable low", cmp_pin, 1'b1);
    chk("R6 compare irq again", irq_cmp, 1'b1);
    rd(AS, d); chk("R6 status bit6 and enable", d, 8'h48);
    wr_cmp(exp_cnt + 16'd2);
    cmp_oe = 1'b1;
    tick_n(2);
    chk("R4 pin driven low", cmp_pin, 1'b0);
    wr(AS, 8'h00);
    chk("R6 irq masked when enable off", irq_cmp, 1'b0);
    rd(AS, d); wr_cmp(16'h0000);
    rd(AS, d); chk("R8 flag cleared", d, 8'h00);
  endtask

  task automatic t_capture;
    logic [7:0] h, l, d;
    logic [15:0] cap_exp;
    wr(AS, 8'h12);
    tick_n(7);
    cap_in = 1'b1; cap_exp = exp_cnt; idle(5);
    chk("R6 capture irq", irq_cap, 1'b1);
    rd(APH, h);
    chk("R9 capture read alone keeps flag", irq_cap, 1'b1);
    rd(APL, l); chk("R5 rising capture value", {h, l}, cap_exp);
    rd(AS, d); chk("R5 status capture flag", d, 8'h92);
    rd(APH, h);
    chk("R9 read then capture read clears", irq_cap, 1'b0);
    tick_n(4);
    cap_in = 1'b0; idle(5);
    chk("R5 falling ignored when rising selected", irq_cap, 1'b0);
    rd(APH, h); rd(APL, l); chk("R5 value unchanged", {h, l}, cap_exp);
    wr(AS, 8'h10);
    tick_n(3);
    cap_in = 1'b1; idle(5);
    chk("R5 rising ignored when falling selected", irq_cap, 1'b0);
    tick_n(2);
    cap_in = 1'b0; cap_exp = exp_cnt; idle(5);
    chk("R5 falling capture flag", irq_cap, 1'b1);
    rd(AS, d);
    rd(APH, h); rd(APL, l); chk("R5 falling capture value", {h, l}, cap_exp);
    rd(AS, d); chk("R9 cleared status", d, 8'h10);
    wr(AS, 8'h00);
  endtask

  task automatic t_overflow;
    logic [7:0] h, l, d;
    wr(AS, 8'h04);
    tick_n(int'(16'hFFFF - exp_cnt) - 1);
    chk("R3 no overflow before top", irq_ovf, 1'b0);
    tick_n(1);
    chk("R3 overflow irq at 0xFFFF", irq_ovf, 1'b1);
    rd(AS, d); chk("R3 status bit5", d[5], 1'b1);
    chk("R7 status read clears", irq_ovf, 1'b0);
    rd(AS, d); chk("R7 bit5 cleared", d[5], 1'b0);
    tick_n(1);
    rd(ACH, h); rd(ACL, l); chk("R2 wrap to zero", {h, l}, 16'h0000);
    chk("R3 no repeat after wrap", irq_ovf, 1'b0);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_status_rw();
    t_count();
    t_compare();
    t_capture();
    t_overflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule